// File: doc/BRIEF.md
# Vector Loop Length Controller

This block walks a vector loop over an array of N elements in strips, on a machine whose widest vector is fixed at build time (`VMAX` elements). Software hands it a pointer just past the last element, the element count and the element size, then pulses `start`. The block keeps a backward index: the number of elements not yet handled. In each iteration it offers the vector unit a granted length and an operand address. The granted length is the backward index, capped at `VMAX`. The address is the end pointer minus the backward index times the element size. The vector unit takes the granted length together with the operand, so the destination register can record its own length.

The vector unit accepts an iteration with a valid/ready handshake. The offer is presented while `it_valid` is high and is taken in a cycle where `it_ready` is also high. While `it_ready` is low the offer stays exactly as it is, and no internal state moves. After each accepted iteration the backward index drops by the granted length. When the index reaches zero, `done` pulses for one cycle. So the last strip always covers exactly the leftover elements. With `VMAX` = 8, ten elements give strips of 8 and 2. With `VMAX` = 16, ten elements give a single strip of 10.

Top module: `vloop_ctrl`

## Requirements
- R1: While `it_valid` is high, `it_len` equals the smaller of the backward index and `VMAX`, and is never zero.
- R2: The first iteration after `start` requests the full element count. Each accepted iteration lowers the backward index by the granted length, so the strip lengths sum to the element count.
- R3: `it_addr` equals `end_ptr` minus (backward index << `elem_sz`), modulo 2^`ADDR_W`. The `elem_sz` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R4: `it_last` is high exactly on the final iteration. In that iteration `it_len` equals the number of elements remaining.
- R5: While `it_valid` is high and `it_ready` is low, `it_valid`, `it_len`, `it_addr` and `it_last` hold their values. The index changes only on a handshake.
- R6: `done` is a one-cycle pulse in the cycle after the final handshake. During that pulse `busy` and `it_valid` are low.
- R7: A `start` with an element count of zero raises `done` in the next cycle, and no iteration is ever offered.
- R8: A `start` that arrives while `busy` is high is ignored. The running strip sequence is unchanged.
- R9: After reset, `busy`, `done` and `it_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop; taken only when idle |
| end_ptr | input | ADDR_W | Byte address just past the array |
| elem_cnt | input | CNT_W | Number of elements N |
| elem_sz | input | 2 | Element size code (0..3 means 1/2/4/8 bytes) |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| it_valid | output | 1 | Iteration offered to the vector unit |
| it_ready | input | 1 | Vector unit accepts the iteration |
| it_len | output | LEN_W | Granted vector length |
| it_addr | output | ADDR_W | Memory operand byte address |
| it_last | output | 1 | Marks the final iteration |

## Verification
A corrupted backward index shows at the ports in the very next offered iteration. It appears as a wrong `it_len` or `it_addr`, and later as a wrong strip count, a wrong `it_last` position, or a `done` pulse that comes early or late. A wrong state encoding shows within one cycle as `it_valid`, `busy` or `done` at the wrong time. Stalls are inserted on purpose, so that any drift of the offered fields during back-pressure is caught in the cycle it happens.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vl_state_e;
endpackage

// File: rtl/vl_clamp.sv
module vl_clamp #(
  parameter int CNT_W = 16,
  parameter int VMAX  = 8,
  localparam int LEN_W = $clog2(VMAX + 1)
) (
  input  logic [CNT_W-1:0] idx,
  output logic [LEN_W-1:0] len
);
  localparam logic [CNT_W-1:0] VMAX_C = CNT_W'(VMAX);

  always_comb begin
    if (idx >= VMAX_C) len = LEN_W'(VMAX);
    else               len = LEN_W'(idx);
  end
endmodule

// File: rtl/vl_addr_gen.sv
module vl_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  idx,
  input  logic [1:0]        sz,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] span;

  always_comb begin
    span = ADDR_W'(idx) << sz;
    addr = base - span;
  end
endmodule

// File: rtl/vl_seq.sv
module vl_seq
  import vloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int VMAX   = 8,
  localparam int LEN_W = $clog2(VMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [CNT_W-1:0]  elem_cnt,
  input  logic [1:0]        elem_sz,
  input  logic              ready,
  input  logic [LEN_W-1:0]  len,
  output logic              valid,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  idx,
  output logic [ADDR_W-1:0] base,
  output logic [1:0]        sz
);
  vl_state_e state;
  logic [CNT_W-1:0] len_ext;

  assign len_ext = CNT_W'(len);
  assign valid   = (state == ST_RUN);
  assign busy    = (state == ST_RUN);
  assign done    = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      base  <= '0;
      sz    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          base  <= end_ptr;
          sz    <= elem_sz;
          idx   <= elem_cnt;
          state <= (elem_cnt == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (ready) begin
          idx <= idx - len_ext;
          if (idx == len_ext) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: index frozen under back-pressure
  p_hold_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(idx));
  // R7: zero count completes at once
  p_zero_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && start && (elem_cnt == '0) |=> done && !valid);
  // R6: done lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: start during a stalled run leaves the base unchanged
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(base) && $stable(sz));
endmodule

// File: rtl/vloop_ctrl.sv
module vloop_ctrl #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int VMAX   = 8,
  localparam int LEN_W = $clog2(VMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [CNT_W-1:0]  elem_cnt,
  input  logic [1:0]        elem_sz,
  output logic              busy,
  output logic              done,
  output logic              it_valid,
  input  logic              it_ready,
  output logic [LEN_W-1:0]  it_len,
  output logic [ADDR_W-1:0] it_addr,
  output logic              it_last
);
  logic [CNT_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic [1:0]        sz;

  vl_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VMAX(VMAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .end_ptr(end_ptr),
    .elem_cnt(elem_cnt), .elem_sz(elem_sz), .ready(it_ready), .len(it_len),
    .valid(it_valid), .busy(busy), .done(done), .idx(idx), .base(base), .sz(sz)
  );

  vl_clamp #(.CNT_W(CNT_W), .VMAX(VMAX)) u_clamp (
    .idx(idx), .len(it_len)
  );

  vl_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .base(base), .idx(idx), .sz(sz), .addr(it_addr)
  );

  assign it_last = it_valid && (idx <= CNT_W'(VMAX));

  // R1: granted length within 1..VMAX
  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    it_valid |-> (it_len != '0) && (32'(it_len) <= VMAX));
  // R5: offered fields hold while stalled
  p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    it_valid && !it_ready |=> it_valid && $stable(it_len) && $stable(it_addr) && $stable(it_last));
  // R4: accepting the last strip ends the loop
  p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    it_valid && it_ready && it_last |=> done && !it_valid);
  // R6: no offer during the done pulse
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !it_valid);
endmodule

// File: tb/vloop_ctrl_test.sv
module vloop_ctrl_test;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NCASE = 6;
  localparam logic [CW-1:0] T_CNT [NCASE] = '{16'd10, 16'd8, 16'd16, 16'd3, 16'd17, 16'd1};
  localparam logic [1:0]    T_SZ  [NCASE] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2};
  localparam logic [AW-1:0] T_PTR [NCASE] = '{32'h0000_1000, 32'h0000_2040, 32'h0001_0000,
                                              32'h0000_0018, 32'h8000_0011, 32'h0000_0004};

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [AW-1:0] end_ptr = '0;
  logic [CW-1:0] elem_cnt = '0;
  logic [1:0] elem_sz = '0;
  logic it_ready = 0;
  logic busy, done, it_valid, it_last;
  logic [3:0] it_len;
  logic [AW-1:0] it_addr;
  logic busy_w, done_w, valid_w, last_w;
  logic [4:0] len_w;
  logic [AW-1:0] addr_w;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vloop_ctrl #(.ADDR_W(AW), .CNT_W(CW), .VMAX(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .end_ptr(end_ptr),
    .elem_cnt(elem_cnt), .elem_sz(elem_sz), .busy(busy), .done(done),
    .it_valid(it_valid), .it_ready(it_ready), .it_len(it_len),
    .it_addr(it_addr), .it_last(it_last)
  );

  vloop_ctrl #(.ADDR_W(AW), .CNT_W(CW), .VMAX(16)) uut_wide (
    .clk(clk), .rst_n(rst_n), .start(start), .end_ptr(end_ptr),
    .elem_cnt(elem_cnt), .elem_sz(elem_sz), .busy(busy_w), .done(done_w),
    .it_valid(valid_w), .it_ready(it_ready), .it_len(len_w),
    .it_addr(addr_w), .it_last(last_w)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Runs one loop on the VMAX=8 instance; stall on the first strip when asked,
  // with a stray start pulse during the stall (R8).
  task automatic run_case(input logic [CW-1:0] cnt, input logic [1:0] sz,
                          input logic [AW-1:0] ptr, input bit stall);
    int rem;
    int exp_len;
    logic [AW-1:0] exp_addr;
    int strips;
    start = 1; elem_cnt = cnt; elem_sz = sz; end_ptr = ptr; it_ready = 0;
    @(negedge clk);
    start = 0;
    rem = cnt;
    strips = 0;
    while (rem > 0) begin
      exp_len = (rem > 8) ? 8 : rem;
      exp_addr = ptr - (AW'(rem) << sz);
      chk(it_valid == 1'b1, "R2 valid", it_valid, 1);
      chk(it_len == 4'(exp_len), "R1 len", it_len, exp_len);
      chk(it_addr == exp_addr, "R3 addr", it_addr, exp_addr);
      chk(it_last == (rem <= 8), "R4 last", it_last, (rem <= 8));
      if (stall && strips == 0) begin
        start = 1; elem_cnt = 16'd5; end_ptr = 32'hDEAD_0000; elem_sz = 2'd3;
        @(negedge clk);
        start = 0;
        chk(it_valid && it_len == 4'(exp_len), "R5 hold len", it_len, exp_len);
        chk(it_addr == exp_addr, "R5 hold addr", it_addr, exp_addr);
      end
      it_ready = 1;
      @(negedge clk);
      it_ready = 0;
      rem -= exp_len;
      strips++;
    end
    chk(done == 1'b1, "R6 done", done, 1);
    chk(!busy && !it_valid, "R6 quiet", {busy, it_valid}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 pulse", done, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !it_valid, "R9 reset", {busy, done, it_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NCASE; i++) begin
      run_case(T_CNT[i], T_SZ[i], T_PTR[i], (i % 2) == 1);
    end

    // R7: zero count
    start = 1; elem_cnt = '0; elem_sz = 2'd1; end_ptr = 32'h100;
    @(negedge clk);
    start = 0;
    chk(done && !it_valid, "R7 zero done", {done, it_valid}, 2);
    @(negedge clk);
    chk(!done && !it_valid && !busy, "R7 zero idle", {done, it_valid, busy}, 0);

    // R4 on the wide instance: ten elements in one strip of ten
    start = 1; elem_cnt = 16'd10; elem_sz = 2'd2; end_ptr = 32'h0000_0400;
    @(negedge clk);
    start = 0;
    chk(valid_w && len_w == 5'd10, "R4 wide len", len_w, 10);
    chk(last_w == 1'b1, "R4 wide last", last_w, 1);
    chk(addr_w == 32'h0000_03D8, "R3 wide addr", addr_w, 32'h3D8);
    it_ready = 1;
    @(negedge clk);
    it_ready = 0;
    chk(done_w == 1'b1, "R6 wide done", done_w, 1);
    chk(done == 1'b0 && it_valid, "R2 narrow still running", {done, it_valid}, 1);
    @(negedge clk);
    it_ready = 1;
    @(negedge clk);
    it_ready = 0;
    chk(done == 1'b1, "R2 narrow two strips", done, 1);
    @(negedge clk);

    // R9: reset in mid-run
    start = 1; elem_cnt = 16'd20;
    @(negedge clk);
    start = 0;
    rst_n = 0;
    @(negedge clk);
    chk(!busy && !it_valid && !done, "R9 mid reset", {busy, it_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule